// File: doc/BRIEF.md
# Lens Actuator Soft-Move Sequencer

This block sequences a voice-coil lens actuator through a byte-wide register request port. It issues address/data requests that a serial bus bridge forwards to the actuator chip. When started, it computes a per-step wait from the configured operating mode, clock prescale and timing field. It then releases power-down and lets the device settle. Next it turns on ringing-control mode, programs the mode, prescale and timing fields, and finally moves the 10-bit lens position up to the requested target in 16-code steps. The step sizes are chosen so that the last step lands exactly on the target.

When stopped, the block walks the position back down to zero in 16-code steps and then puts the device into power-down. While the block is powered and idle, it forwards single position updates straight to the device. A `tick` strobe supplies the microsecond time base for every wait. An error response to any request aborts the running sequence, returns the block to the powered-off idle state and sets a sticky error flag.

Top module: `lens_ramp_seq`

## Requirements
- R1: After reset the block is powered-off idle: `busy`, `on_idle`, `err_flag` and `req_valid` are all 0.
- R2: A start request taken in powered-off idle issues a write of 0x00 to address 0x02. It then waits at least SETTLE_US ticks and writes 0x02 to address 0x02. Next it reads address 0x06 and writes back the read value with bits 7:5 replaced by the mode and bits 4:0 kept. Address 0x02 is never written with a value other than 0x00, 0x01 or 0x02.
- R3: If the prescale is not 1, a second read of 0x06 follows. It is followed by a write of that value with bits 2:0 replaced by the prescale and bits 7:3 kept. If the prescale is 1, both requests are left out.
- R4: If the timing field is not 0x20, a write of {2'b00, timing} to address 0x07 follows. If it is 0x20, the write is left out.
- R5: The start ramp writes positions target mod 16, then +16 per step, up to and including the target. Each position goes out as a write to 0x03 carrying bits 9:8 in data bits 1:0 (data bits 7:2 zero), followed by a write to 0x04 carrying bits 7:0. Afterwards the block is powered-on idle.
- R6: After each ramp position write to 0x04, the next request is held back for at least `step_us` ticks.
- R7: `step_us` = (63 + timing) × rate × mult / 100, rounded down. The rate for prescale 0,1,2,3,4,5 is 200,100,50,25,800,400, and 100 for any other value. The mult for mode 1,2,3,5 is 48,70,75,113, and 70 for any other value. It is computed once per start.
- R8: A stop request taken in powered-on idle ramps the position down from the current position rounded down to a multiple of 16, in steps of 16, to 0 inclusive. It waits `step_us` ticks after each step and then writes 0x01 to address 0x02. At least SETTLE_US ticks later the block is powered-off idle.
- R9: A direct position write is sent as the 0x03/0x04 pair with no wait, and only in powered-on idle. In any other state it issues no request.
- R10: Start and stop requests are ignored while `busy` is 1. A start request is also ignored in powered-on idle.
- R11: An error response aborts the sequence: within two cycles `busy` is 0, `on_idle` is 0 and `err_flag` is 1. `err_flag` then stays 1 until reset.
- R12: `req_valid` stays high with stable address, data and direction until `req_ready` is seen.
- R13: Waits count `tick` strobes, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per microsecond |
| start_req | input | 1 | Power up and ramp to target |
| stop_req | input | 1 | Ramp to zero and power down |
| target_pos | input | POS_W | Target position sampled on start |
| cfg_mode | input | 3 | Operating mode field |
| cfg_presc | input | 3 | Clock prescale field |
| cfg_timing | input | 6 | Timing field |
| pos_wr_valid | input | 1 | Direct position update strobe |
| pos_wr_data | input | POS_W | Direct position value |
| req_valid | output | 1 | Register request valid |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 8 | Write data |
| req_ready | input | 1 | Request accepted |
| rsp_valid | input | 1 | Response strobe |
| rsp_err | input | 1 | Response carries an error |
| rsp_rdata | input | 8 | Read data |
| busy | output | 1 | A sequence is running |
| on_idle | output | 1 | Powered-on and idle |
| err_flag | output | 1 | Sticky error |
| step_us | output | WAIT_W | Computed per-step wait in ticks |

## Verification
The assertions check the following every cycle: the request handshake holding its contents, the legal control-register values, the zero upper bits of the position-high byte, the abort timing after an error response and the stickiness of the error flag. Only the bench scenarios can show the rest. That covers the full order of requests in start and stop sequences, the read-modify-write merges and skipped writes, the ramp positions and step alignment, and the minimum gaps between steps under dense and sparse ticks. It also covers the step-wait arithmetic across every mode and prescale value.

// File: rtl/lens_ramp_pkg.sv
package lens_ramp_pkg;
  localparam logic [7:0] ADR_CTRL   = 8'h02;
  localparam logic [7:0] ADR_POS_HI = 8'h03;
  localparam logic [7:0] ADR_POS_LO = 8'h04;
  localparam logic [7:0] ADR_MODE   = 8'h06;
  localparam logic [7:0] ADR_TIME   = 8'h07;

  localparam logic [7:0] CTRL_ACTIVE = 8'h00;
  localparam logic [7:0] CTRL_PDOWN  = 8'h01;
  localparam logic [7:0] CTRL_RING   = 8'h02;

  localparam logic [2:0] DEF_PRESC = 3'd1;
  localparam logic [5:0] DEF_TIME  = 6'h20;

  typedef enum logic [4:0] {
    S_OFF, S_CALC, S_PD_CLR, S_SETTLE_UP, S_RING, S_MODE_RD, S_MODE_WR,
    S_PRE_RD, S_PRE_WR, S_TIM_WR, S_UP_HI, S_UP_LO, S_UP_WAIT, S_ON,
    S_DIR_HI, S_DIR_LO, S_DN_HI, S_DN_LO, S_DN_WAIT, S_PD_SET, S_SETTLE_DN
  } seq_state_t;

  function automatic logic [9:0] rate_pct(input logic [2:0] p);
    case (p)
      3'd0: rate_pct = 10'd200;
      3'd2: rate_pct = 10'd50;
      3'd3: rate_pct = 10'd25;
      3'd4: rate_pct = 10'd800;
      3'd5: rate_pct = 10'd400;
      default: rate_pct = 10'd100;
    endcase
  endfunction

  function automatic logic [6:0] mult_pct(input logic [2:0] m);
    case (m)
      3'd1: mult_pct = 7'd48;
      3'd3: mult_pct = 7'd75;
      3'd5: mult_pct = 7'd113;
      default: mult_pct = 7'd70;
    endcase
  endfunction
endpackage

// File: rtl/step_wait_calc.sv
module step_wait_calc
  import lens_ramp_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [2:0]       mode,
  input  logic [2:0]       presc,
  input  logic [5:0]       timing,
  output logic             done,
  output logic [OUT_W-1:0] wait_us
);
  localparam int CW = $clog2(OUT_W + 1);
  localparam logic [7:0] DIVISOR = 8'd100;

  typedef enum logic [1:0] {C_IDLE, C_MUL, C_DIV} calc_ph_t;
  calc_ph_t ph;
  logic [OUT_W-1:0] acc;
  logic [6:0]       rem;
  logic [CW-1:0]    cnt;
  logic [7:0]       trial;
  logic             ge;

  assign trial   = {rem, acc[OUT_W-1]};
  assign ge      = trial >= DIVISOR;
  assign wait_us = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= C_IDLE;
      acc  <= '0;
      rem  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      case (ph)
        C_IDLE: begin
          done <= 1'b0;
          if (go) begin
            acc <= (OUT_W'(timing) + OUT_W'(63)) * OUT_W'(rate_pct(presc));
            ph  <= C_MUL;
          end
        end
        C_MUL: begin
          acc <= acc * OUT_W'(mult_pct(mode));
          rem <= '0;
          cnt <= '0;
          ph  <= C_DIV;
        end
        default: begin
          rem <= ge ? 7'(trial - DIVISOR) : trial[6:0];
          acc <= {acc[OUT_W-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OUT_W - 1)) begin
            done <= 1'b1;
            ph   <= C_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tick_wait.sv
module tick_wait #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/reg_req_port.sv
module reg_req_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic [DW-1:0] rsp_rdata
);
  typedef enum logic [1:0] {B_IDLE, B_REQ, B_RSP} bus_ph_t;
  bus_ph_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= B_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        B_IDLE: if (go) begin
          req_valid <= 1'b1;
          req_write <= wr;
          req_addr  <= addr;
          req_wdata <= wdata;
          ph        <= B_REQ;
        end
        B_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          ph        <= B_RSP;
        end
        default: if (rsp_valid) begin
          done  <= 1'b1;
          err   <= rsp_err;
          rdata <= rsp_rdata;
          ph    <= B_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lens_ramp_seq.sv
module lens_ramp_seq
  import lens_ramp_pkg::*;
#(
  parameter int POS_W     = 10,
  parameter int STEP_Q    = 16,
  parameter int SETTLE_US = 1000,
  parameter int WAIT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic [POS_W-1:0]  target_pos,
  input  logic [2:0]        cfg_mode,
  input  logic [2:0]        cfg_presc,
  input  logic [5:0]        cfg_timing,
  input  logic              pos_wr_valid,
  input  logic [POS_W-1:0]  pos_wr_data,
  output logic              req_valid,
  output logic              req_write,
  output logic [7:0]        req_addr,
  output logic [7:0]        req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_rdata,
  output logic              busy,
  output logic              on_idle,
  output logic              err_flag,
  output logic [WAIT_W-1:0] step_us
);
  localparam int PW = POS_W + 1;
  localparam logic [PW-1:0] STEP = PW'(STEP_Q);
  localparam logic [PW-1:0] LOW_MASK = PW'(STEP_Q - 1);

  seq_state_t state;
  logic launched;
  logic [PW-1:0] pos, tgt, cur;
  logic [2:0] mode_q, presc_q;
  logic [5:0] tim_q;
  logic [7:0] rmw;

  logic bus_st, wait_st, cmd_wr;
  logic [7:0] cmd_addr, cmd_data;
  logic bus_done, bus_err;
  logic [7:0] bus_rdata;
  logic calc_done, tmr_exp;
  logic [WAIT_W-1:0] calc_val, tmr_val;

  always_comb begin
    bus_st   = 1'b1;
    cmd_wr   = 1'b1;
    cmd_addr = ADR_CTRL;
    cmd_data = CTRL_ACTIVE;
    case (state)
      S_PD_CLR:  cmd_data = CTRL_ACTIVE;
      S_RING:    cmd_data = CTRL_RING;
      S_PD_SET:  cmd_data = CTRL_PDOWN;
      S_MODE_RD, S_PRE_RD: begin
        cmd_wr   = 1'b0;
        cmd_addr = ADR_MODE;
      end
      S_MODE_WR: begin
        cmd_addr = ADR_MODE;
        cmd_data = {mode_q, rmw[4:0]};
      end
      S_PRE_WR: begin
        cmd_addr = ADR_MODE;
        cmd_data = {rmw[7:3], presc_q};
      end
      S_TIM_WR: begin
        cmd_addr = ADR_TIME;
        cmd_data = {2'b00, tim_q};
      end
      S_UP_HI, S_DN_HI, S_DIR_HI: begin
        cmd_addr = ADR_POS_HI;
        cmd_data = 8'(pos[POS_W-1:8]);
      end
      S_UP_LO, S_DN_LO, S_DIR_LO: begin
        cmd_addr = ADR_POS_LO;
        cmd_data = pos[7:0];
      end
      default: bus_st = 1'b0;
    endcase
  end

  assign wait_st = (state == S_SETTLE_UP) || (state == S_SETTLE_DN) ||
                   (state == S_UP_WAIT) || (state == S_DN_WAIT);
  assign tmr_val = (state == S_UP_WAIT || state == S_DN_WAIT) ? step_us
                                                               : WAIT_W'(SETTLE_US);

  reg_req_port #(.AW(8), .DW(8)) u_port (
    .clk(clk), .rst(rst), .go(bus_st && !launched), .wr(cmd_wr),
    .addr(cmd_addr), .wdata(cmd_data), .done(bus_done), .err(bus_err),
    .rdata(bus_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  step_wait_calc #(.OUT_W(WAIT_W)) u_calc (
    .clk(clk), .rst(rst), .go(state == S_CALC && !launched),
    .mode(mode_q), .presc(presc_q), .timing(tim_q),
    .done(calc_done), .wait_us(calc_val)
  );

  tick_wait #(.W(WAIT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(wait_st && !launched), .val(tmr_val),
    .tick(tick), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_OFF;
      launched <= 1'b0;
      pos      <= '0;
      tgt      <= '0;
      cur      <= '0;
      mode_q   <= '0;
      presc_q  <= '0;
      tim_q    <= '0;
      rmw      <= '0;
      err_flag <= 1'b0;
      step_us  <= '0;
    end else if (bus_st) begin
      if (!launched) launched <= 1'b1;
      else if (bus_done) begin
        launched <= 1'b0;
        if (bus_err) begin
          err_flag <= 1'b1;
          state    <= S_OFF;
        end else begin
          case (state)
            S_PD_CLR:  state <= S_SETTLE_UP;
            S_RING:    state <= S_MODE_RD;
            S_MODE_RD: begin rmw <= bus_rdata; state <= S_MODE_WR; end
            S_MODE_WR:
              if (presc_q != DEF_PRESC) state <= S_PRE_RD;
              else if (tim_q != DEF_TIME) state <= S_TIM_WR;
              else state <= S_UP_HI;
            S_PRE_RD:  begin rmw <= bus_rdata; state <= S_PRE_WR; end
            S_PRE_WR:  state <= (tim_q != DEF_TIME) ? S_TIM_WR : S_UP_HI;
            S_TIM_WR:  state <= S_UP_HI;
            S_UP_HI:   state <= S_UP_LO;
            S_UP_LO:   state <= S_UP_WAIT;
            S_DIR_HI:  state <= S_DIR_LO;
            S_DIR_LO:  begin cur <= pos; state <= S_ON; end
            S_DN_HI:   state <= S_DN_LO;
            S_DN_LO:   state <= S_DN_WAIT;
            default:   state <= S_SETTLE_DN;
          endcase
        end
      end
    end else if (wait_st) begin
      if (!launched) launched <= 1'b1;
      else if (tmr_exp) begin
        launched <= 1'b0;
        case (state)
          S_SETTLE_UP: state <= S_RING;
          S_UP_WAIT:
            if (pos + STEP > tgt) begin
              cur   <= tgt;
              state <= S_ON;
            end else begin
              pos   <= pos + STEP;
              state <= S_UP_HI;
            end
          S_DN_WAIT:
            if (pos == '0) state <= S_PD_SET;
            else begin
              pos   <= pos - STEP;
              state <= S_DN_HI;
            end
          default: state <= S_OFF;
        endcase
      end
    end else begin
      case (state)
        S_OFF: if (start_req) begin
          mode_q  <= cfg_mode;
          presc_q <= cfg_presc;
          tim_q   <= cfg_timing;
          tgt     <= PW'(target_pos);
          pos     <= PW'(target_pos) & LOW_MASK;
          state   <= S_CALC;
        end
        S_CALC:
          if (!launched) launched <= 1'b1;
          else if (calc_done) begin
            launched <= 1'b0;
            step_us  <= calc_val;
            state    <= S_PD_CLR;
          end
        S_ON:
          if (stop_req) begin
            pos   <= cur & ~LOW_MASK;
            state <= S_DN_HI;
          end else if (pos_wr_valid) begin
            pos   <= PW'(pos_wr_data);
            state <= S_DIR_HI;
          end
        default: state <= S_OFF;
      endcase
    end
  end

  assign busy    = (state != S_OFF) && (state != S_ON);
  assign on_idle = (state == S_ON);
endmodule

// File: rtl/lens_ramp_seq_chk.sv
module lens_ramp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       busy,
  input logic       on_idle,
  input logic       err_flag
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
                                $stable(req_wdata) && $stable(req_write));

  a_r2_ctrl_values: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && req_addr == 8'h02 |-> req_wdata <= 8'h02);

  a_r5_hi_byte: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_addr == 8'h03 |-> req_wdata[7:2] == 6'd0);

  a_r11_abort: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |=> ##1 (!busy && !on_idle && err_flag));

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  a_r9_quiet_off: assert property (@(posedge clk) disable iff (rst)
    !busy && !on_idle |-> !req_valid);
endmodule

bind lens_ramp_seq lens_ramp_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .busy(busy),
  .on_idle(on_idle), .err_flag(err_flag)
);

// File: tb/lens_ramp_seq_tb.sv
module lens_ramp_seq_tb;
  localparam int SETTLE = 40;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic start_req = 0, stop_req = 0, pos_wr_valid = 0;
  logic [9:0] target_pos = '0, pos_wr_data = '0;
  logic [2:0] cfg_mode = '0, cfg_presc = '0;
  logic [5:0] cfg_timing = '0;
  logic req_valid, req_write, req_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic [7:0] req_addr, req_wdata, rsp_rdata = '0;
  logic busy, on_idle, err_flag;
  logic [31:0] step_us;

  lens_ramp_seq #(.SETTLE_US(SETTLE)) u_dut (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int tick_div = 1, stall = 0, err_at = -1;
  logic [7:0] regs [8];
  int n_log = 0;
  logic [7:0] lg_addr [256], lg_data [256];
  logic lg_wr [256];
  int lg_cyc [256];
  int n_ex = 0;
  logic [7:0] ex_addr [256], ex_data [256];
  logic ex_wr [256];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
  end

  // register-port responder
  initial begin
    bit due = 0, err_nx = 0;
    int st = 0;
    logic [7:0] rd = '0;
    forever begin
      @(negedge clk);
      req_ready = 0; rsp_valid = 0; rsp_err = 0;
      if (due) begin
        rsp_valid = 1; rsp_err = err_nx; rsp_rdata = rd; due = 0;
      end else if (req_valid) begin
        if (st < stall) st++;
        else begin
          st = 0; req_ready = 1;
          lg_addr[n_log] = req_addr; lg_data[n_log] = req_wdata;
          lg_wr[n_log] = req_write; lg_cyc[n_log] = cyc;
          err_nx = (n_log == err_at);
          if (req_write) regs[req_addr[2:0]] = req_wdata;
          else rd = regs[req_addr[2:0]];
          if (n_log < 255) n_log++;
          due = 1;
        end
      end
    end
  end

  function automatic longint ref_step(input int m, input int p, input int t);
    longint r, k;
    case (p) 0: r = 200; 2: r = 50; 3: r = 25; 4: r = 800; 5: r = 400; default: r = 100; endcase
    case (m) 1: k = 48; 3: k = 75; 5: k = 113; default: k = 70; endcase
    return (63 + t) * r * k / 100;
  endfunction

  task automatic push(input logic w, input logic [7:0] a, input logic [7:0] d);
    ex_wr[n_ex] = w; ex_addr[n_ex] = a; ex_data[n_ex] = d; n_ex++;
  endtask

  task automatic push_pos(input int p);
    push(1, 8'h03, 8'(p >> 8)); push(1, 8'h04, 8'(p & 255));
  endtask

  task automatic exp_start(input int tgt, input int m, input int p, input int t);
    logic [7:0] r6 = regs[6];
    push(1, 8'h02, 8'h00); push(1, 8'h02, 8'h02); push(0, 8'h06, 8'h00);
    r6 = {3'(m), r6[4:0]}; push(1, 8'h06, r6);
    if (p != 1) begin push(0, 8'h06, 8'h00); r6 = {r6[7:3], 3'(p)}; push(1, 8'h06, r6); end
    if (t != 32) push(1, 8'h07, 8'(t));
    for (int q = tgt % 16; q <= tgt; q += 16) push_pos(q);
  endtask

  task automatic cmp_log(input string tag);
    int bad = -1;
    for (int i = 0; i < n_ex && i < n_log; i++)
      if (bad < 0 && (lg_wr[i] != ex_wr[i] || lg_addr[i] != ex_addr[i] ||
          (ex_wr[i] && lg_data[i] != ex_data[i]))) bad = i;
    check(n_log == n_ex, {tag, " request count"}, n_log, n_ex);
    if (bad >= 0)
      check(0, {tag, " request content"}, {lg_addr[bad], lg_data[bad]}, {ex_addr[bad], ex_data[bad]});
    else check(1, tag, 0, 0);
  endtask

  task automatic clr(); n_log = 0; n_ex = 0; endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic do_start(input int tgt, input int m, input int p, input int t);
    @(negedge clk);
    start_req = 1; target_pos = 10'(tgt); cfg_mode = 3'(m); cfg_presc = 3'(p); cfg_timing = 6'(t);
    @(negedge clk); start_req = 0;
  endtask

  task automatic step_gaps(input string tag, input longint minv, input longint maxv);
    bit ok = 1; longint g = 0;
    for (int i = 0; i + 1 < n_log; i++)
      if (lg_wr[i] && lg_addr[i] == 8'h04) begin
        g = lg_cyc[i+1] - lg_cyc[i];
        if (g < minv || g > maxv) ok = 0;
      end
    check(ok, tag, g, minv);
  endtask

  initial begin
    int t_off;
    longint s;
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    regs[6] = 8'h1B;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !on_idle && !err_flag && !req_valid, "R1 reset state", {busy, on_idle, err_flag}, 0);

    // R9 direct write ignored while off
    clr(); pos_wr_valid = 1; pos_wr_data = 10'd300; @(negedge clk); pos_wr_valid = 0;
    repeat (20) @(negedge clk);
    check(n_log == 0 && !on_idle, "R9 direct write while off", n_log, 0);

    // start: mode 1, prescale 3, timing 0, target 37, handshake stalls
    clr(); stall = 1; s = ref_step(1, 3, 0);
    exp_start(37, 1, 3, 0);
    do_start(37, 1, 3, 0);
    repeat (60) @(negedge clk);
    start_req = 1; stop_req = 1; pos_wr_valid = 1; pos_wr_data = 10'd999;  // R10 ignored while busy
    @(negedge clk); start_req = 0; stop_req = 0; pos_wr_valid = 0;
    wait_idle();
    cmp_log("R2 R3 R4 R5 R10 start sequence");
    check(step_us == s, "R7 step wait m1 p3 t0", step_us, s);
    check(lg_cyc[1] - lg_cyc[0] >= SETTLE, "R2 settle gap", lg_cyc[1] - lg_cyc[0], SETTLE);
    step_gaps("R6 step gaps", s, s + 12);
    check(on_idle && !err_flag, "R5 powered idle after ramp", on_idle, 1);
    stall = 0;

    // R10 start ignored in powered idle
    clr(); do_start(5, 2, 1, 32); repeat (30) @(negedge clk);
    check(n_log == 0 && on_idle, "R10 start while on", n_log, 0);

    // R9 direct write straight through
    clr(); pos_wr_valid = 1; pos_wr_data = 10'd700; @(negedge clk); pos_wr_valid = 0;
    wait_idle(); push_pos(700);
    cmp_log("R9 direct write");
    check(lg_cyc[1] - lg_cyc[0] <= 6, "R9 no wait in direct write", lg_cyc[1] - lg_cyc[0], 6);

    // R8 stop ramp from 700
    clr();
    for (int q = 688; q >= 0; q -= 16) push_pos(q);
    push(1, 8'h02, 8'h01);
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
    wait_idle(); t_off = cyc;
    cmp_log("R8 stop sequence");
    check(!on_idle && !busy, "R8 off after stop", on_idle, 0);
    check(t_off - lg_cyc[n_log-1] >= SETTLE, "R8 settle after power-down", t_off - lg_cyc[n_log-1], SETTLE);

    // defaults with sparse ticks: no prescale or timing writes
    clr(); tick_div = 2; s = ref_step(2, 1, 32);
    exp_start(31, 2, 1, 32);
    do_start(31, 2, 1, 32); wait_idle();
    cmp_log("R3 R4 skipped default writes");
    check(step_us == s, "R7 step wait defaults", step_us, s);
    check(lg_cyc[1] - lg_cyc[0] >= 2 * (SETTLE - 1), "R13 settle counts ticks",
          lg_cyc[1] - lg_cyc[0], 2 * (SETTLE - 1));
    step_gaps("R13 step gaps count ticks", 2 * (s - 1), 2 * s + 12);
    clr(); push_pos(16); push_pos(0); push(1, 8'h02, 8'h01);
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
    wait_idle();
    cmp_log("R8 stop from 31");
    tick_div = 1;

    // R11 error on third request
    clr(); err_at = 2;
    do_start(100, 5, 2, 10); wait_idle();
    repeat (20) @(negedge clk);
    check(n_log == 3, "R11 abort stops requests", n_log, 3);
    check(err_flag && !on_idle && !busy, "R11 sticky error and off", err_flag, 1);

    // R7 sweep, each run aborted by an error on its first request
    err_at = 0;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 2; k++) begin
          int t = k ? 63 : 0;
          clr(); s = ref_step(m, p, t);
          do_start(50, m, p, t); wait_idle();
          check(step_us == s, $sformatf("R7 step wait m%0d p%0d t%0d", m, p, t), step_us, s);
        end
    check(err_flag, "R11 error flag still set", err_flag, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule